// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is the slave side of a three-wire serial port: a chip-enable input, a shift clock input and one data line that changes direction. Through it a host reads and writes a file of sixteen 4-bit registers. The host raises chip enable and sends frames of eight shift-clock pulses. Every frame opens with four control bits, then carries a 4-bit nibble. Depending on the control bits, that nibble either loads an internal address register or is written to the register that address selects. A read request makes the port drive the data line during the frame that follows.

The port never uses the shift clock as a clock. All three pins go through two-flop synchronizers in the fast system clock domain, and the port acts on the edges it detects there. The system clock must run at least eight times faster than the shift clock. The data line is split into an input, an output and an output enable, which the pad ring combines.

On the register-file side the port gives an address, a one-cycle write strobe with write data, and a read-data input. It also gives a one-cycle pulse on every fall of chip enable. The register file uses that pulse to set its clock-carry enable bit (entry 14, bit 1) and its test bit (entry 15, bit 0) back to 1.

Top module: `tw_reg_port`

## Requirements
- R1: After synchronous reset, `sio_oe`, `rf_wr` and `rf_force` are 0 and `rf_addr` is 0.
- R2: Data-line bits are captured on falling shift-clock edges. A frame's bit order is: one ignored bit, R/W, AD, DT, then nibble bit 3 down to bit 0. A frame's register-side result registers on the third system-clock edge after the pin change of its eighth falling edge.
- R3: A frame with AD=1 and DT=0 loads its nibble into the address register, which drives `rf_addr`. Every other control combination leaves the address register unchanged.
- R4: A frame with DT=1, R/W=0 and AD=0 gives a one-cycle `rf_wr` with `rf_wdata` equal to its nibble, at the current `rf_addr`. No other combination writes.
- R5: After a frame with R/W=1, AD=1 and DT=0, the next frame is an output frame. In it, `sio_oe` rises at the rising edge of clock 2. `rf_rdata` is sampled at that same edge. Bits 3..0 of the sampled value are driven on `sio_o` from the rising edges of clocks 5 through 8.
- R6: The output frame is not decoded as a command. `sio_oe` falls at the rising edge of the first clock of the next frame, and that frame is decoded as a control frame.
- R7: While chip enable stays high, frames run back to back. A write may follow a read without dropping chip enable. A frame whose R/W, AD and DT are all 0 has no effect.
- R8: With chip enable low, `sio_oe` is 0 and the frame position is reset. A frame cut short by chip enable falling causes no write, and the next frame after chip enable rises again is decoded from its first bit.
- R9: Each fall of chip enable gives exactly one one-cycle `rf_force` pulse, three system-clock edges after the pin falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Chip enable pin, active high |
| sclk_i | input | 1 | Shift clock pin |
| sio_i | input | 1 | Data line, input side |
| sio_o | output | 1 | Data line, output value |
| sio_oe | output | 1 | Data line output enable |
| rf_addr | output | 4 | Register file address |
| rf_wr | output | 1 | Register write strobe, one cycle |
| rf_wdata | output | 4 | Register write data |
| rf_rdata | input | 4 | Register read data at `rf_addr` |
| rf_force | output | 1 | Pulse that sets the carry-enable and test bits |

## Verification
Every result of the port, whether address, strobe, output enable, data bit or force pulse, registers on the third system-clock edge after the pin change that causes it: two edges of synchronization, then one registered action. The bench reference model keeps a three-deep history of the pins it drove and applies the frame rules to the entry two edges old against the one three edges old. Pins are driven and outputs compared on the falling system-clock edge, so each expected value sits in the same cycle as the design's. Directed checks time a write strobe at exactly three cycles after the eighth falling shift-clock edge. They read serial data five cycles after each rising shift-clock edge, which is well after the value is due.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;

    localparam int NIB_W     = 4;
    localparam int CTL_W     = 4;
    localparam int FRAME_LEN = CTL_W + NIB_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    // holds bits 1..6 of a frame; bit 0 is ignored and bit 7 arrives live
    localparam int SH_W      = FRAME_LEN - 2;
    localparam int RF_DEPTH  = 1 << NIB_W;

    localparam int PIN_CE   = 0;
    localparam int PIN_SCLK = 1;
    localparam int PIN_SIO  = 2;
    localparam int PIN_N    = 3;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic {
        FK_CMD = 1'b0,
        FK_OUT = 1'b1
    } fkind_e;

    typedef struct packed {
        logic rw;
        logic ad;
        logic dt;
        nib_t nib;
    } frame_t;

    function automatic logic is_addr_load(frame_t f);
        return f.ad & ~f.dt;
    endfunction

    function automatic logic is_data_write(frame_t f);
        return f.dt & ~f.rw & ~f.ad;
    endfunction

    function automatic logic is_read_req(frame_t f);
        return f.rw & f.ad & ~f.dt;
    endfunction

endpackage

// File: rtl/tw_pin_sync.sv
`timescale 1ns/1ps
module tw_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tw_frame_ctl.sv
`timescale 1ns/1ps
module tw_frame_ctl
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_lvl,
    input  logic             ce_fall,
    input  logic             sclk_fall,
    input  logic             sio_lvl,
    output logic [CNT_W-1:0] cnt_o,
    output fkind_e           kind_o,
    output nib_t             addr_o,
    output logic             wr_o,
    output nib_t             wdata_o,
    output logic             force_o
);
    logic [SH_W-1:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;
    fkind_e           kind_q;
    nib_t             addr_q, wdata_q;
    logic             wr_q, force_q;
    frame_t           fr;
    logic             last_bit;

    assign fr       = frame_t'({sh_q, sio_lvl});
    assign last_bit = (cnt_q == CNT_W'(FRAME_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            kind_q  <= FK_CMD;
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
            force_q <= 1'b0;
        end else begin
            wr_q    <= 1'b0;
            force_q <= ce_fall;
            if (!ce_lvl) begin
                sh_q   <= '0;
                cnt_q  <= '0;
                kind_q <= FK_CMD;
            end else if (sclk_fall) begin
                sh_q <= {sh_q[SH_W-2:0], sio_lvl};
                if (last_bit) begin
                    cnt_q <= '0;
                    if (kind_q == FK_CMD) begin
                        if (is_addr_load(fr)) addr_q <= fr.nib;
                        if (is_data_write(fr)) begin
                            wr_q    <= 1'b1;
                            wdata_q <= fr.nib;
                        end
                        kind_q <= is_read_req(fr) ? FK_OUT : FK_CMD;
                    end else begin
                        kind_q <= FK_CMD;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt_o   = cnt_q;
    assign kind_o  = kind_q;
    assign addr_o  = addr_q;
    assign wr_o    = wr_q;
    assign wdata_o = wdata_q;
    assign force_o = force_q;
endmodule

// File: rtl/tw_sio_drv.sv
`timescale 1ns/1ps
module tw_sio_drv
    import tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_lvl,
    input  logic             sclk_rise,
    input  logic [CNT_W-1:0] cnt_i,
    input  fkind_e           kind_i,
    input  nib_t             rdata_i,
    output logic             oe_o,
    output logic             dout_o
);
    nib_t obuf_q;
    logic oe_q, dout_q;

    always_ff @(posedge clk) begin
        if (rst || !ce_lvl) begin
            obuf_q <= '0;
            oe_q   <= 1'b0;
            dout_q <= 1'b0;
        end else if (sclk_rise) begin
            if (kind_i == FK_OUT) begin
                if (cnt_i == CNT_W'(1)) begin
                    oe_q   <= 1'b1;
                    obuf_q <= rdata_i;
                    dout_q <= 1'b0;
                end else if (cnt_i >= CNT_W'(CTL_W)) begin
                    dout_q <= obuf_q[NIB_W-1];
                    obuf_q <= {obuf_q[NIB_W-2:0], 1'b0};
                end
            end else begin
                oe_q   <= 1'b0;
                dout_q <= 1'b0;
            end
        end
    end

    assign oe_o   = oe_q;
    assign dout_o = dout_q;
endmodule

// File: rtl/tw_reg_port.sv
`timescale 1ns/1ps
module tw_reg_port
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_i,
    input  logic             sclk_i,
    input  logic             sio_i,
    output logic             sio_o,
    output logic             sio_oe,
    output logic [NIB_W-1:0] rf_addr,
    output logic             rf_wr,
    output logic [NIB_W-1:0] rf_wdata,
    input  logic [NIB_W-1:0] rf_rdata,
    output logic             rf_force
);
    logic [PIN_N-1:0] lvl;
    logic [1:0]       prv;
    logic             ce_lvl, ce_fall, sclk_fall, sclk_rise, out_frame;
    logic [CNT_W-1:0] cnt;
    fkind_e           kind;

    tw_pin_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({sio_i, sclk_i, ce_i}),
        .q_o (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prv <= '0;
        else     prv <= lvl[PIN_SCLK:PIN_CE];
    end

    assign ce_lvl    = lvl[PIN_CE];
    assign ce_fall   = prv[PIN_CE] & ~lvl[PIN_CE];
    assign sclk_fall = prv[PIN_SCLK] & ~lvl[PIN_SCLK];
    assign sclk_rise = ~prv[PIN_SCLK] & lvl[PIN_SCLK];
    assign out_frame = (kind == FK_OUT);

    tw_frame_ctl i_frame (
        .clk       (clk),
        .rst       (rst),
        .ce_lvl    (ce_lvl),
        .ce_fall   (ce_fall),
        .sclk_fall (sclk_fall),
        .sio_lvl   (lvl[PIN_SIO]),
        .cnt_o     (cnt),
        .kind_o    (kind),
        .addr_o    (rf_addr),
        .wr_o      (rf_wr),
        .wdata_o   (rf_wdata),
        .force_o   (rf_force)
    );

    tw_sio_drv i_drv (
        .clk       (clk),
        .rst       (rst),
        .ce_lvl    (ce_lvl),
        .sclk_rise (sclk_rise),
        .cnt_i     (cnt),
        .kind_i    (kind),
        .rdata_i   (rf_rdata),
        .oe_o      (sio_oe),
        .dout_o    (sio_o)
    );
endmodule

// File: rtl/tw_port_chk.sv
`timescale 1ns/1ps
module tw_port_chk
    import tw_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       ce_lvl,
    input logic       sclk_rise,
    input logic       sclk_fall,
    input logic       out_frame,
    input logic       sio_oe,
    input logic       rf_wr,
    input logic       rf_force,
    input nib_t       rf_addr
);
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> !rf_wr);

    a_r4_strobe_follows_fall: assert property (@(posedge clk) disable iff (rst)
        rf_wr |-> $past(sclk_fall));

    a_r3_addr_holds: assert property (@(posedge clk) disable iff (rst)
        !sclk_fall |=> $stable(rf_addr));

    a_r5_oe_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
        (ce_lvl && !sclk_rise) |=> $stable(sio_oe));

    a_r6_oe_only_out_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(sio_oe) |-> $past(out_frame));

    a_r8_idle_when_ce_low: assert property (@(posedge clk) disable iff (rst)
        !ce_lvl |=> !sio_oe);

    a_r9_force_single: assert property (@(posedge clk) disable iff (rst)
        rf_force |=> !rf_force);
endmodule

bind tw_reg_port tw_port_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .ce_lvl    (ce_lvl),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .out_frame (out_frame),
    .sio_oe    (sio_oe),
    .rf_wr     (rf_wr),
    .rf_force  (rf_force),
    .rf_addr   (rf_addr)
);

// File: tb/test_tw_reg_port.sv
`timescale 1ns/1ps
module test_tw_reg_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0, sclk = 1'b0, sio_in = 1'b0;
    logic sio_o, sio_oe, rf_wr, rf_force;
    logic [3:0] rf_addr, rf_wdata, rf_rdata;
    logic [3:0] regs [16];

    int nchk = 0, nerr = 0, cyc = 0, fall_cyc = 0, force_cnt = 0, ce_falls = 0;
    bit oe_seen [8];

    always #4 clk = ~clk;

    assign rf_rdata = regs[rf_addr];

    tw_reg_port i_tw_reg_port (
        .clk(clk), .rst(rst), .ce_i(ce), .sclk_i(sclk), .sio_i(sio_in),
        .sio_o(sio_o), .sio_oe(sio_oe), .rf_addr(rf_addr), .rf_wr(rf_wr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .rf_force(rf_force)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    // reference model: behaviour per frame rules, pins seen after a 3-edge latency
    logic [2:0] h [3];
    int m_cnt;
    bit m_out, m_wr, m_force, m_oe, m_dout;
    logic [3:0] m_addr, m_wdata, m_obuf;
    logic [7:0] m_bits;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
        if (rst) begin
            for (int i = 0; i < 3; i++) h[i] = 3'b000;
            for (int i = 0; i < 16; i++) regs[i] <= 4'h0;
            m_cnt = 0; m_out = 0; m_wr = 0; m_force = 0; m_oe = 0; m_dout = 0;
            m_addr = 0; m_wdata = 0; m_obuf = 0; m_bits = 0;
        end else begin
            logic [2:0] old_p, new_p;
            old_p = h[2];
            new_p = h[1];
            m_wr = 0;
            m_force = old_p[0] && !new_p[0];
            if (!new_p[0]) begin
                m_cnt = 0; m_out = 0; m_oe = 0; m_dout = 0; m_obuf = 0; m_bits = 0;
            end else if (old_p[1] && !new_p[1]) begin
                m_bits = {m_bits[6:0], new_p[2]};
                m_cnt++;
                if (m_cnt == 8) begin
                    m_cnt = 0;
                    if (!m_out) begin
                        if (m_bits[5] && !m_bits[4]) m_addr = m_bits[3:0];
                        if (m_bits[4] && !m_bits[6] && !m_bits[5]) begin
                            m_wr = 1; m_wdata = m_bits[3:0];
                            regs[m_addr] <= m_wdata;
                        end
                        m_out = m_bits[6] && m_bits[5] && !m_bits[4];
                    end else m_out = 0;
                end
            end else if (!old_p[1] && new_p[1]) begin
                if (m_out) begin
                    if (m_cnt == 1) begin
                        m_oe = 1; m_obuf = regs[m_addr]; m_dout = 0;
                    end else if (m_cnt >= 4) begin
                        m_dout = m_obuf[3]; m_obuf = {m_obuf[2:0], 1'b0};
                    end
                end else begin
                    m_oe = 0; m_dout = 0;
                end
            end
            if (m_force) begin
                regs[14][1] <= 1'b1;
                regs[15][0] <= 1'b1;
            end
            h[2] = h[1]; h[1] = h[0]; h[0] = {sio_in, sclk, ce};
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3", "rf_addr", rf_addr, m_addr);
            chk("R4", "rf_wr", rf_wr, m_wr);
            chk("R4", "rf_wdata", rf_wdata, m_wdata);
            chk("R5", "sio_oe", sio_oe, m_oe);
            chk("R5", "sio_o", sio_o, m_dout);
            chk("R9", "rf_force", rf_force, m_force);
            if (rf_wr) chk("R2", "strobe latency", cyc - fall_cyc, 3);
            if (rf_force) force_cnt++;
        end
    end

    task automatic half();
        repeat (6) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] b, output logic [3:0] got, input int nbits = 8);
        got = 4'h0;
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            sio_in = b[7-i];
            repeat (5) @(negedge clk);
            oe_seen[i] = sio_oe;
            if (i >= 4) got[7-i] = sio_o;
            @(negedge clk);
            sclk = 1'b0;
            fall_cyc = cyc;
            half();
        end
    endtask

    task automatic ce_up();
        ce = 1'b1;
        half();
    endtask

    task automatic ce_down();
        ce = 1'b0;
        ce_falls++;
        half();
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
        logic [3:0] g;
        frame({4'b0010, a}, g);
        frame({4'b0001, d}, g);
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic [3:0] exp, input string req);
        logic [3:0] g;
        frame({4'b0110, a}, g);
        frame(8'b0001_1111, g);
        chk(req, "serial read value", g, exp);
    endtask

    initial begin
        logic [3:0] g;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "sio_oe after reset", sio_oe, 0);
        chk("R1", "rf_wr after reset", rf_wr, 0);
        chk("R1", "rf_force after reset", rf_force, 0);
        chk("R1", "rf_addr after reset", rf_addr, 0);

        ce_up();
        wr_reg(4'h5, 4'hA);
        frame(8'b0110_0101, g);
        frame(8'b0001_1111, g);
        chk("R5", "read of 5, MSB first (R2)", g, 4'hA);
        chk("R5", "oe low at clock 1", oe_seen[0], 0);
        chk("R5", "oe high at clock 2", oe_seen[1], 1);

        // write right after the read, CE held high
        frame(8'b0010_0011, g);
        chk("R6", "oe released at clock 1 of next frame", oe_seen[0], 0);
        frame(8'b0001_0110, g);
        rd_reg(4'h3, 4'h6, "R7");
        rd_reg(4'h5, 4'hA, "R6");

        // AD=1 with DT=1 must not move the address
        frame(8'b0011_1001, g);
        chk("R3", "address kept after AD+DT", rf_addr, 4'h5);
        frame(8'b0001_1100, g);
        rd_reg(4'h5, 4'hC, "R3");
        rd_reg(4'h9, 4'h0, "R3");

        // combinations that must not write
        frame(8'b0010_0011, g);
        frame(8'b0101_0111, g);
        frame(8'b0111_0111, g);
        frame(8'b1000_0111, g);
        rd_reg(4'h3, 4'h6, "R4");
        frame(8'b0000_0000, g);
        chk("R7", "all-zero frame no write", rf_wdata, 4'hC);
        ce_down();
        chk("R8", "oe low with CE low", sio_oe, 0);

        // partial frame cut by CE
        ce_up();
        frame(8'b0010_0011, g);
        frame(8'b0001_0101, g, 6);
        ce_down();
        ce_up();
        rd_reg(4'h3, 4'h6, "R8");

        // carry-enable and test bits forced by CE fall
        wr_reg(4'hE, 4'h0);
        wr_reg(4'hF, 4'h0);
        rd_reg(4'hE, 4'h0, "R9");
        ce_down();
        ce_up();
        rd_reg(4'hE, 4'h2, "R9");
        rd_reg(4'hF, 4'h1, "R9");
        ce_down();
        chk("R9", "force pulses per CE fall", force_cnt, ce_falls);
        finish_run();
    end
endmodule